// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block follows a CAN node's fault-confinement condition. A protocol engine, which is not part of this block, pulses increment and decrement strobes for the receive and transmit error counters. The block keeps both counters and works out whether the node is error-active, in the warning band, error-passive or bus-off. It also latches five kinds of frame error reported by the engine.

Software sees the block through a small register window. A status word holds the resolved state bits and the sticky frame-error flags, and reading it clears those flags. A counter word returns both error counts. A 13-bit interrupt mask is changed through separate set and clear write ports and can be read back. One interrupt line is asserted whenever a status bit that is enabled in the mask is set.

After bus-off the node stays silent until a restart pulse arrives. The restart pulse returns both counters to zero, which brings the node back to error-active.

Top module: `can_fault_tracker`

## Requirements
- R1: After reset both counters are zero, the mask is zero and all frame-error flags are clear. The status word (address 0x10) reads 0x0001_0000, the counter word (address 0x20) reads 0 and `irq` is low.
- R2: The counter word carries the receive count in bits 7:0 and the transmit count in bits 23:16. All other bits read zero. A receive increment adds 1 and a transmit increment adds 8. A decrement subtracts 1 and stops at 0. When an increment and a decrement arrive together, the increment is taken. The receive count saturates at 255.
- R3: Status bit 17 (warning) is the only state bit set when either count is 96 or more, neither count is 128 or more, and the node is not bus-off. At 95 and below, bit 16 (active) is set instead.
- R4: Status bit 18 (passive) is the only state bit set when either count is above 127 and the node is not bus-off. At 127 the node falls back to warning.
- R5: A transmit increment that would take the transmit count past 255 enters bus-off. Bus-off sets status bit 19 and leaves the transmit count at 255. While bus-off, all counter strobes are ignored.
- R6: A restart pulse clears both counters and leaves bus-off, so the status word then reads 0x0001_0000.
- R7: Exactly one of status bits 16 to 19 is set at any time. The state is resolved in priority order: bus-off, then passive, then warning, then active.
- R8: Frame-error input bit i (0 CRC, 1 stuffing, 2 acknowledge, 3 form, 4 bit) sets status bit 24+i one cycle later. Each flag stays set until the status word is read. That read returns the flags and clears them. A frame error that arrives in the same cycle as the read is kept.
- R9: Writing to address 0x04 sets the mask bits where the write data is 1. Writing to address 0x08 clears them. Address 0x0C reads the mask back. Only bits 16 to 28 exist, so every other mask bit reads 0.
- R10: `irq` is the OR over all bits of (status AND mask). It follows a mask or status change from the next cycle.
- R11: Reads of any address other than 0x0C, 0x10 and 0x20 return 0. Reading any address other than 0x10 leaves the frame-error flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_err_inc | input | 1 | Receive error counter increment strobe |
| rx_err_dec | input | 1 | Receive error counter decrement strobe |
| tx_err_inc | input | 1 | Transmit error counter increment strobe |
| tx_err_dec | input | 1 | Transmit error counter decrement strobe |
| frame_err_evt | input | 5 | Frame-error event pulses (CRC, stuffing, acknowledge, form, bit) |
| restart | input | 1 | Clears both counters and leaves bus-off |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid in the cycle of the read |
| irq | output | 1 | Combined interrupt |

## Verification
Counter, state, flag and mask updates all take effect at the clock edge where their strobe is sampled. They can be seen through a read or on `irq` in the very next cycle. Read data is combinational, so a read shows the registers as they stood before that read's own edge. This is why a flag that arrives during a status read appears only on the following read. The bench changes inputs on the falling edge and holds each strobe for a whole cycle. It compares results 5 ns after the next falling edge, with every expected value queued by the driver task that issued the read or the interrupt probe.

// File: rtl/can_fc_pkg.sv
// Package: shared encodings for the CAN fault confinement tracker.
// Assumes a 32-bit register window with byte addresses.
package can_fc_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_WARNING = 2'd1,
        FC_PASSIVE = 2'd2,
        FC_BUSOFF  = 2'd3
    } fc_state_e;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int NUM_ST    = 4;
    localparam int NUM_FERR  = 5;
    localparam int ST_LSB    = 16;
    localparam int FERR_LSB  = 24;
    localparam int IRQ_LSB   = 16;
    localparam int IRQ_MSB   = FERR_LSB + NUM_FERR - 1;
    localparam int IRQ_W     = IRQ_MSB - IRQ_LSB + 1;
    localparam int RXCNT_LSB = 0;
    localparam int TXCNT_LSB = 16;

    localparam logic [ADDR_W-1:0] A_MASK_SET = 8'h04;
    localparam logic [ADDR_W-1:0] A_MASK_CLR = 8'h08;
    localparam logic [ADDR_W-1:0] A_MASK_RD  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_STATUS   = 8'h10;
    localparam logic [ADDR_W-1:0] A_ERRCNT   = 8'h20;

endpackage

// File: rtl/fc_err_counter.sv
// Module: one saturating error counter.
// Adds STEP on inc and subtracts 1 on dec, with inc taking precedence.
// The count stops at the top value and at zero. It is frozen while hold
// is set and zeroed by clr. Assumes STEP is smaller than 2**W.
module fc_err_counter #(
    parameter int W    = 8,
    parameter int STEP = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         hold,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count
);
    localparam logic [W:0] STEP_V = (W+1)'(STEP);

    logic [W:0] sum;

    // Candidate value for an increment, one bit wider to see overflow.
    always_comb begin
        sum = {1'b0, count} + STEP_V;
    end

    // Counter register: clear, hold, saturating add, floored subtract.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (hold) begin
            count <= count;
        end else if (inc) begin
            count <= sum[W] ? '1 : sum[W-1:0];
        end else if (dec && (count != '0)) begin
            count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/fc_state_resolver.sv
// Module: combinational fault-confinement state decoder.
// Turns the two counts and the bus-off flag into a priority-resolved
// state and a one-hot state vector (bit 0 active .. bit 3 bus-off).
module fc_state_resolver
    import can_fc_pkg::*;
#(
    parameter int W             = 8,
    parameter int WARN_LIMIT    = 96,
    parameter int PASSIVE_LIMIT = 128
) (
    input  logic          [W-1:0]  rx_cnt,
    input  logic          [W-1:0]  tx_cnt,
    input  logic                   bus_off,
    output fc_state_e              state,
    output logic          [NUM_ST-1:0] state_bits
);
    localparam logic [W-1:0] WARN_V    = W'(WARN_LIMIT);
    localparam logic [W-1:0] PASSIVE_V = W'(PASSIVE_LIMIT);

    logic warn_hit;
    logic pass_hit;

    // Threshold comparators on either counter.
    always_comb begin
        warn_hit = (rx_cnt >= WARN_V) || (tx_cnt >= WARN_V);
        pass_hit = (rx_cnt >= PASSIVE_V) || (tx_cnt >= PASSIVE_V);
    end

    // Priority resolution: bus-off, passive, warning, active.
    always_comb begin
        if (bus_off)       state = FC_BUSOFF;
        else if (pass_hit) state = FC_PASSIVE;
        else if (warn_hit) state = FC_WARNING;
        else               state = FC_ACTIVE;
    end

    // One-hot encoding of the resolved state.
    for (genvar s = 0; s < NUM_ST; s++) begin : g_onehot
        assign state_bits[s] = (state == fc_state_e'(s));
    end

endmodule

// File: rtl/fc_frame_err_latch.sv
// Module: sticky frame-error flags.
// An event sets its flag, and a status read clears all flags.
// An event in the same cycle as the read survives the clear.
module fc_frame_err_latch #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         rd_clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Per-flag latch: set has priority over read clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          flags[i] <= 1'b0;
            else if (evt[i])     flags[i] <= 1'b1;
            else if (rd_clr)     flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/fc_reg_file.sv
// Module: register window and interrupt combiner.
// Holds the interrupt mask, which has separate set and clear writes,
// and assembles the status and counter words. The read mux is
// combinational, so data is valid in the cycle bus_rd is high.
module fc_reg_file
    import can_fc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [NUM_ST-1:0]   state_bits,
    input  logic [NUM_FERR-1:0] ferr_flags,
    input  logic [W-1:0]        rx_cnt,
    input  logic [W-1:0]        tx_cnt,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq
);
    logic [IRQ_W-1:0]  mask_q;
    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] mask_w;
    logic [DATA_W-1:0] cnt_w;
    logic [IRQ_W-1:0]  wr_bits;

    // Slice of write data that lands on implemented mask bits.
    always_comb begin
        wr_bits = bus_wdata[IRQ_MSB:IRQ_LSB];
    end

    // Mask register: write-one-to-set and write-one-to-clear ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (bus_wr && (bus_addr == A_MASK_SET)) begin
            mask_q <= mask_q | wr_bits;
        end else if (bus_wr && (bus_addr == A_MASK_CLR)) begin
            mask_q <= mask_q & ~wr_bits;
        end
    end

    // Word images of status, mask and counters.
    always_comb begin
        status_w = '0;
        status_w[ST_LSB +: NUM_ST]     = state_bits;
        status_w[FERR_LSB +: NUM_FERR] = ferr_flags;
        mask_w = '0;
        mask_w[IRQ_MSB:IRQ_LSB] = mask_q;
        cnt_w = '0;
        cnt_w[RXCNT_LSB +: W] = rx_cnt;
        cnt_w[TXCNT_LSB +: W] = tx_cnt;
    end

    // Read mux; unmapped or write-only addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_MASK_RD: bus_rdata = mask_w;
                A_STATUS:  bus_rdata = status_w;
                A_ERRCNT:  bus_rdata = cnt_w;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // Interrupt combiner over enabled status bits.
    always_comb begin
        irq = |(status_w & mask_w);
    end

endmodule

// File: rtl/can_fault_tracker.sv
// Module: top of the CAN fault confinement tracker.
// Wires the two error counters, the bus-off flag, the state resolver,
// the frame-error latch and the register window together.
// Assumes CNT_W <= 8 so that each count fits its 8-bit field.
module can_fault_tracker
    import can_fc_pkg::*;
#(
    parameter int CNT_W         = 8,
    parameter int RX_STEP       = 1,
    parameter int TX_STEP       = 8,
    parameter int WARN_LIMIT    = 96,
    parameter int PASSIVE_LIMIT = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_err_inc,
    input  logic                rx_err_dec,
    input  logic                tx_err_inc,
    input  logic                tx_err_dec,
    input  logic [NUM_FERR-1:0] frame_err_evt,
    input  logic                restart,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq
);
    localparam logic [CNT_W-1:0] TX_EDGE = CNT_W'((1 << CNT_W) - 1 - TX_STEP);

    logic [CNT_W-1:0]    rx_cnt;
    logic [CNT_W-1:0]    tx_cnt;
    logic                bus_off;
    logic                off_trig;
    logic                stat_rd;
    fc_state_e           state;
    logic [NUM_ST-1:0]   state_bits;
    logic [NUM_FERR-1:0] ferr_q;

    fc_err_counter #(.W(CNT_W), .STEP(RX_STEP)) u_rx_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .hold  (bus_off),
        .inc   (rx_err_inc),
        .dec   (rx_err_dec),
        .count (rx_cnt)
    );

    fc_err_counter #(.W(CNT_W), .STEP(TX_STEP)) u_tx_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .hold  (bus_off),
        .inc   (tx_err_inc),
        .dec   (tx_err_dec),
        .count (tx_cnt)
    );

    // Detect a transmit increment that would run past the counter top.
    always_comb begin
        off_trig = tx_err_inc && !bus_off && !restart && (tx_cnt > TX_EDGE);
    end

    // Bus-off flag: entered on transmit overflow, left only by restart.
    always_ff @(posedge clk) begin
        if (!rst_n)        bus_off <= 1'b0;
        else if (restart)  bus_off <= 1'b0;
        else if (off_trig) bus_off <= 1'b1;
    end

    fc_state_resolver #(
        .W             (CNT_W),
        .WARN_LIMIT    (WARN_LIMIT),
        .PASSIVE_LIMIT (PASSIVE_LIMIT)
    ) u_resolve (
        .rx_cnt     (rx_cnt),
        .tx_cnt     (tx_cnt),
        .bus_off    (bus_off),
        .state      (state),
        .state_bits (state_bits)
    );

    // Status read strobe that clears the frame-error flags.
    always_comb begin
        stat_rd = bus_rd && (bus_addr == A_STATUS);
    end

    fc_frame_err_latch #(.N(NUM_FERR)) u_ferr (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (frame_err_evt),
        .rd_clr (stat_rd),
        .flags  (ferr_q)
    );

    fc_reg_file #(.W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .state_bits (state_bits),
        .ferr_flags (ferr_q),
        .rx_cnt     (rx_cnt),
        .tx_cnt     (tx_cnt),
        .bus_rdata  (bus_rdata),
        .irq        (irq)
    );

endmodule

// File: rtl/can_fault_tracker_chk.sv
// Checker: temporal properties of the fault confinement tracker,
// attached to every instance of the top through bind.
module can_fault_tracker_chk
    import can_fc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rx_err_inc,
    input logic                rx_err_dec,
    input logic                restart,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [NUM_FERR-1:0] frame_err_evt,
    input logic                irq,
    input logic                bus_off,
    input logic [CNT_W-1:0]    rx_cnt,
    input logic [CNT_W-1:0]    tx_cnt,
    input logic [NUM_FERR-1:0] ferr_q,
    input logic [NUM_ST-1:0]   state_bits
);
    p_rx_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0 && rx_err_dec && !rx_err_inc) |=> (rx_cnt == '0));

    p_busoff_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && !restart) |=> bus_off);

    p_busoff_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && !restart) |=> ($stable(rx_cnt) && $stable(tx_cnt)));

    p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (rx_cnt == '0 && tx_cnt == '0 && !bus_off));

    p_one_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_bits));

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STATUS && frame_err_evt == '0) |=> (ferr_q == '0));

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err_evt != '0) |=> ((ferr_q & $past(frame_err_evt)) == $past(frame_err_evt)));

    p_mask_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MASK_CLR && bus_wdata == '1) |=> !irq);

endmodule

bind can_fault_tracker can_fault_tracker_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_err_inc    (rx_err_inc),
    .rx_err_dec    (rx_err_dec),
    .restart       (restart),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .frame_err_evt (frame_err_evt),
    .irq           (irq),
    .bus_off       (bus_off),
    .rx_cnt        (rx_cnt),
    .tx_cnt        (tx_cnt),
    .ferr_q        (ferr_q),
    .state_bits    (state_bits)
);

// File: tb/can_fault_tracker_test.sv
// Bench: scoreboard style. Driver tasks queue expected read or irq
// values; a monitor pops and compares them 5 ns after each falling edge.
module can_fault_tracker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_err_inc = 1'b0;
    logic        rx_err_dec = 1'b0;
    logic        tx_err_inc = 1'b0;
    logic        tx_err_dec = 1'b0;
    logic [4:0]  frame_err_evt = '0;
    logic        restart = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    logic     mon_rd  = 1'b0;
    logic     mon_irq = 1'b0;
    int       n_cmp   = 0;
    int       n_bad   = 0;

    can_fault_tracker uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_err_inc    (rx_err_inc),
        .rx_err_dec    (rx_err_dec),
        .tx_err_inc    (tx_err_inc),
        .tx_err_dec    (tx_err_dec),
        .frame_err_evt (frame_err_evt),
        .restart       (restart),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq           (irq)
    );

    always #10 clk = ~clk;

    // Monitor: compare the result due in this cycle with the queue head.
    always @(negedge clk) begin
        #5;
        if (mon_rd || mon_irq) begin
            if (sb_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL scoreboard empty");
            end else begin
                sb_item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : bus_rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e,
                          input string tag, input logic [4:0] ev = '0);
        sb_item_t it;
        @(negedge clk);
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1; mon_rd = 1'b1; frame_err_evt = ev;
        @(negedge clk);
        bus_rd = 1'b0; mon_rd = 1'b0; frame_err_evt = '0;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        sb_item_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        mon_irq = 1'b1;
        @(negedge clk);
        mon_irq = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Strobe vector order: {rx_inc, rx_dec, tx_inc, tx_dec}, held n cycles.
    task automatic strobe(input logic [3:0] v, input int n);
        @(negedge clk);
        {rx_err_inc, rx_err_dec, tx_err_inc, tx_err_dec} = v;
        repeat (n) @(negedge clk);
        {rx_err_inc, rx_err_dec, tx_err_inc, tx_err_dec} = '0;
    endtask

    task automatic pulse_restart();
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
    endtask

    task automatic pulse_evt(input logic [4:0] v);
        @(negedge clk); frame_err_evt = v;
        @(negedge clk); frame_err_evt = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 20);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(8'h20, 32'h0000_0000, "R1 counters");
        rd_chk(8'h10, 32'h0001_0000, "R1 status");
        rd_chk(8'h0C, 32'h0000_0000, "R1 mask");
        irq_chk(1'b0, "R1 irq");
        // R2 counting, floor, precedence
        strobe(4'b1000, 5);
        rd_chk(8'h20, 32'h0000_0005, "R2 rx inc");
        strobe(4'b0100, 2);
        rd_chk(8'h20, 32'h0000_0003, "R2 rx dec");
        strobe(4'b0100, 5);
        rd_chk(8'h20, 32'h0000_0000, "R2 rx floor");
        strobe(4'b0010, 3);
        rd_chk(8'h20, 32'h0018_0000, "R2 tx step 8");
        strobe(4'b0011, 1);
        rd_chk(8'h20, 32'h0020_0000, "R2 inc over dec");
        // R3 warning band and its lower edge
        strobe(4'b1000, 96);
        rd_chk(8'h10, 32'h0002_0000, "R3 warning at 96");
        rd_chk(8'h20, 32'h0020_0060, "R2 layout both");
        strobe(4'b0100, 1);
        rd_chk(8'h10, 32'h0001_0000, "R3 active at 95");
        // R4 passive and its edge
        strobe(4'b1000, 33);
        rd_chk(8'h10, 32'h0004_0000, "R4 passive at 128");
        strobe(4'b0100, 1);
        rd_chk(8'h10, 32'h0002_0000, "R4 warning at 127");
        strobe(4'b0010, 27);
        rd_chk(8'h10, 32'h0004_0000, "R4 passive tx 248");
        rd_chk(8'h20, 32'h00F8_007F, "R2 counts 248/127");
        // R5 bus-off and R7 priority
        strobe(4'b0010, 1);
        rd_chk(8'h10, 32'h0008_0000, "R5 R7 bus-off only");
        rd_chk(8'h20, 32'h00FF_007F, "R5 tx held at 255");
        strobe(4'b1001, 3);
        rd_chk(8'h20, 32'h00FF_007F, "R5 strobes ignored");
        rd_chk(8'h10, 32'h0008_0000, "R5 still bus-off");
        // R6 restart
        pulse_restart();
        rd_chk(8'h20, 32'h0000_0000, "R6 counters zero");
        rd_chk(8'h10, 32'h0001_0000, "R6 active again");
        // R2 rx saturation, R7 rx alone never bus-off
        strobe(4'b1000, 260);
        rd_chk(8'h20, 32'h0000_00FF, "R2 rx saturates");
        rd_chk(8'h10, 32'h0004_0000, "R7 rx max is passive");
        pulse_restart();
        // R8 frame-error flags
        pulse_evt(5'b00101);
        rd_chk(8'h10, 32'h0501_0000, "R8 crc+ack flags");
        rd_chk(8'h10, 32'h0001_0000, "R8 cleared by read");
        pulse_evt(5'b10000);
        rd_chk(8'h20, 32'h0000_0000, "R11 cnt read");
        rd_chk(8'h10, 32'h1001_0000, "R11 flag kept");
        rd_chk(8'h10, 32'h0001_0000, "R8 bit flag cleared", 5'b01000);
        rd_chk(8'h10, 32'h0801_0000, "R8 same-cycle event kept");
        rd_chk(8'h10, 32'h0001_0000, "R8 form flag cleared");
        // R9 mask and R10 irq
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h0C, 32'h1FFF_0000, "R9 mask set");
        irq_chk(1'b1, "R10 active enabled");
        wr(8'h08, 32'h0001_0000);
        rd_chk(8'h0C, 32'h1FFE_0000, "R9 mask clear");
        irq_chk(1'b0, "R10 active masked");
        pulse_evt(5'b00100);
        irq_chk(1'b1, "R10 ack flag irq");
        rd_chk(8'h10, 32'h0401_0000, "R8 ack flag");
        irq_chk(1'b0, "R10 irq after clear");
        wr(8'h08, 32'hFFFF_FFFF);
        rd_chk(8'h0C, 32'h0000_0000, "R9 mask all clear");
        // R11 unmapped reads
        rd_chk(8'h04, 32'h0000_0000, "R11 set port read");
        rd_chk(8'h14, 32'h0000_0000, "R11 unmapped read");
        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard left %0d items", sb_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule